// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of nine bus masters may drive the shared bus next. Index 0 is the master built into the chip and indices 1 to 8 are external masters. Each master has one active-low request input and one active-low grant output. A small configuration register splits the masters into two groups. Members of the high group take turns one after another. The whole low group shares one turn in that rotation, and its own members take that shared turn in strict rotation.

Priorities change only when a new bus transaction begins, which is marked by the active-low frame input going from idle to active. At that point, the master whose grant was active is credited with the transaction and becomes the lowest-priority member of its own group. Between those points, the grant follows the best active request and moves to a higher-priority requester one clock after that requester appears. When nothing is requested, the grant rests on the internal master. A new group split is written at any time but only applies from the next transaction start.

Top module: `rr2_arbiter`

## Requirements
- R1: After reset the configuration is internal master (index 0) high and indices 1..8 low, and with no request active the grant rests on index 0 (gntN == 9'h1FE).
- R2: With the reset configuration and all nine requests held active, successive transactions are granted in the order 0,1,0,2,0,3,...,0,8,0,1.
- R3: With indices 0..3 in the high group (register value 9'h00F) and all requests active, the order is 0,1,2,3,4,0,1,2,3,5,0,1,2,3,6: the low group fills one slot after index 3 and advances by one member per visit.
- R4: With every master in the high group (register value 9'h1FF), the masters are granted in plain index order 0..8 and then wrap.
- R5: With every master in the low group (register value 9'h000), the masters are granted in plain index order 0..8 and then wrap.
- R6: Re-evaluation happens only on a clock where frameN is sampled low after being sampled high; holding frameN low for several clocks advances the rotation exactly once.
- R7: A grant goes only to a master whose request was active on the previous clock. When a higher-priority request appears, the grant moves to it on the next clock. A new lower-priority request does not move the grant.
- R8: Exactly one grant output is low in every clock after reset, so a switch removes the old grant in the same clock the new one appears.
- R9: When no request is active, the grant moves to index 0 on the next clock.
- R10: A write to the group register (cfgWe high, bit i set puts master i in the high group) has no effect on grants until the next re-evaluation. After that, each group's rotation skips masters that have left it.
- R11: A transaction is credited to the master whose grant was active when frame was first seen, not to the master that would have had top priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Active-low transaction frame, sampled each clock |
| reqN | input | 9 | Active-low request, one bit per master |
| cfgWe | input | 1 | Write strobe for the group register |
| cfgData | input | 9 | New group split, 1 = high group |
| gntN | output | 9 | Active-low grant, one bit per master |

## Verification
The rotation is driven with every request held active under four splits: the reset split, four high plus five low, all high and all low. Together these separate the shared low-group slot from plain round-robin, and show that both degenerate splits fall back to simple rotation. Sparse request patterns show three things: pre-emption by a higher requester, that a new lower requester is ignored, and resting on the internal master when idle. A held frame shows that re-evaluation fires on the edge and not on the level. A single low requester followed by a full request set shows that credit goes to the granted master. A write followed by mixed requests shows that the split is deferred and that the rotation skips a master that changed group.

// File: rtl/rr2_pkg.sv
package rr2_pkg;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic reEval;    // transaction start seen: rotate pointers
    logic loadMask;  // adopt the pending group split
  } rr2_strobe_t;

endpackage

// File: rtl/rr2_ctrl.sv
module rr2_ctrl
  import rr2_pkg::*;
#(
  parameter int N    = 9,
  parameter int PARK = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameN,
  input  logic         cfgWe,
  input  logic [N-1:0] cfgData,
  output logic [N-1:0] pendMask,
  output rr2_strobe_t  strb
);

  localparam logic [N-1:0] RST_MASK = N'(1) << PARK;

  logic frameQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ   <= 1'b1;
      pendMask <= RST_MASK;
    end else begin
      frameQ <= frameN;
      if (cfgWe) pendMask <= cfgData;
    end
  end

  always_comb begin
    strb.reEval   = frameQ && !frameN;
    strb.loadMask = frameQ && !frameN;
  end

endmodule

// File: rtl/rr2_pick.sv
module rr2_pick #(
  parameter int N    = 9,
  parameter int PARK = 0,
  localparam int IW  = $clog2(N),
  localparam int SW  = $clog2(N + 1)
) (
  input  logic [N-1:0]  reqVec,
  input  logic [N-1:0]  hiMask,
  input  logic [SW-1:0] hiPtr,
  input  logic [IW-1:0] loPtr,
  output logic [N-1:0]  winOneHot
);

  logic loFound;
  int   loIdx;
  logic found;

  // first low-group requester at or after loPtr
  always_comb begin
    loFound = 1'b0;
    loIdx   = 0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(loPtr) + k;
      if (j >= N) j = j - N;
      if (!loFound && reqVec[j] && !hiMask[j]) begin
        loFound = 1'b1;
        loIdx   = j;
      end
    end
  end

  // ring of N high positions plus one slot (position N) for the low group
  always_comb begin
    found     = 1'b0;
    winOneHot = '0;
    for (int k = 0; k <= N; k++) begin
      int p;
      p = int'(hiPtr) + k;
      if (p > N) p = p - (N + 1);
      if (!found) begin
        if (p == N) begin
          if (loFound) begin
            found            = 1'b1;
            winOneHot[loIdx] = 1'b1;
          end
        end else if (hiMask[p] && reqVec[p]) begin
          found        = 1'b1;
          winOneHot[p] = 1'b1;
        end
      end
    end
    if (!found) winOneHot[PARK] = 1'b1;
  end

endmodule

// File: rtl/rr2_datapath.sv
module rr2_datapath
  import rr2_pkg::*;
#(
  parameter int N    = 9,
  parameter int PARK = 0,
  localparam int IW  = $clog2(N),
  localparam int SW  = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] reqN,
  input  logic [N-1:0] pendMask,
  input  rr2_strobe_t  strb,
  output logic [N-1:0] gntN
);

  localparam logic [N-1:0] RST_MASK = N'(1) << PARK;

  logic [N-1:0]  hiMask;
  logic [SW-1:0] hiPtr;
  logic [IW-1:0] loPtr;
  logic [N-1:0]  grantQ;
  logic [N-1:0]  winOneHot;
  logic [IW-1:0] credIdx;
  logic          credHigh;

  rr2_pick #(.N(N), .PARK(PARK)) u_pick (
    .reqVec   (~reqN),
    .hiMask   (hiMask),
    .hiPtr    (hiPtr),
    .loPtr    (loPtr),
    .winOneHot(winOneHot)
  );

  // index of the master holding the grant now
  always_comb begin
    credIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grantQ[i]) credIdx = IW'(i);
    end
    credHigh = hiMask[credIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiMask <= RST_MASK;
      hiPtr  <= '0;
      loPtr  <= '0;
      grantQ <= RST_MASK;
    end else begin
      grantQ <= winOneHot;
      if (strb.reEval) begin
        if (credHigh) begin
          hiPtr <= SW'(credIdx) + SW'(1);
        end else begin
          hiPtr <= '0;
          loPtr <= (credIdx == IW'(N - 1)) ? '0 : credIdx + IW'(1);
        end
      end
      if (strb.loadMask) hiMask <= pendMask;
    end
  end

  assign gntN = ~grantQ;

endmodule

// File: rtl/rr2_arbiter.sv
module rr2_arbiter
  import rr2_pkg::*;
#(
  parameter int N    = 9,
  parameter int PARK = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameN,
  input  logic [N-1:0] reqN,
  input  logic         cfgWe,
  input  logic [N-1:0] cfgData,
  output logic [N-1:0] gntN
);

  rr2_strobe_t  strb;
  logic [N-1:0] pendMask;

  rr2_ctrl #(.N(N), .PARK(PARK)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .cfgWe   (cfgWe),
    .cfgData (cfgData),
    .pendMask(pendMask),
    .strb    (strb)
  );

  rr2_datapath #(.N(N), .PARK(PARK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqN    (reqN),
    .pendMask(pendMask),
    .strb    (strb),
    .gntN    (gntN)
  );

endmodule

// File: rtl/rr2_arbiter_chk.sv
module rr2_arbiter_chk
  import rr2_pkg::*;
#(
  parameter int N    = 9,
  parameter int PARK = 0
) (
  input logic         clk,
  input logic         rstN,
  input logic         frameN,
  input logic [N-1:0] reqN,
  input logic [N-1:0] gntN,
  input rr2_strobe_t  strb
);

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~gntN) == 1);

  // R9
  idle_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&reqN) |=> (gntN == ~(N'(1) << PARK)));

  // R7
  grant_requested_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(&reqN) |=> ((~gntN & ~$past(reqN)) != '0));

  // R6
  reeval_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reEval |-> (!frameN && $past(frameN)));

  // R6
  no_reeval_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameN |-> !strb.reEval);

endmodule

bind rr2_arbiter rr2_arbiter_chk #(.N(N), .PARK(PARK)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .frameN(frameN),
  .reqN  (reqN),
  .gntN  (gntN),
  .strb  (strb)
);

// File: tb/rr2_arbiter_tb.sv
module rr2_arbiter_tb;

  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rstN;
  logic         frameN;
  logic [N-1:0] reqN;
  logic         cfgWe;
  logic [N-1:0] cfgData;
  logic [N-1:0] gntN;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  rr2_arbiter #(.N(N), .PARK(0)) u_dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .reqN(reqN),
    .cfgWe(cfgWe), .cfgData(cfgData), .gntN(gntN)
  );

  always #10 clk = ~clk;

  task automatic chkGnt(input int exp, input string tag);
    logic [N-1:0] want;
    want = ~(N'(1) << exp);
    checks++;
    if (gntN !== want) begin
      errors++;
      $display("FAIL %s: gntN=%h expected %h (master %0d)", tag, gntN, want, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; frameN = 1'b1; reqN = '1; cfgWe = 1'b0; cfgData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setReq(input logic [N-1:0] active);
    reqN = ~active;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [N-1:0] m);
    cfgWe = 1'b1; cfgData = m;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // check current grant, then run one transaction start
  task automatic txn(input int exp, input string tag);
    chkGnt(exp, tag);
    frameN = 1'b0;
    @(negedge clk);
    frameN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tResetPark();
    doReset();
    chkGnt(0, "R1 reset idle grant");
    setReq(9'h010);
    chkGnt(4, "R7 lone requester");
    setReq(9'h000);
    chkGnt(0, "R9 idle returns to park");
  endtask

  task automatic tDefaultRot();
    int seq[18] = '{0,1,0,2,0,3,0,4,0,5,0,6,0,7,0,8,0,1};
    doReset();
    setReq(9'h1FF);
    foreach (seq[i]) txn(seq[i], "R2 default rotation");
  endtask

  task automatic tExample();
    int seq[15] = '{0,1,2,3,4,0,1,2,3,5,0,1,2,3,6};
    doReset();
    setReq(9'h1FF);
    writeCfg(9'h00F);
    foreach (seq[i]) txn(seq[i], "R3 low group slot");
  endtask

  task automatic tAllHigh();
    int seq[11] = '{0,1,2,3,4,5,6,7,8,0,1};
    doReset();
    setReq(9'h1FF);
    writeCfg(9'h1FF);
    foreach (seq[i]) txn(seq[i], "R4 all high round robin");
  endtask

  task automatic tAllLow();
    int seq[11] = '{0,0,1,2,3,4,5,6,7,8,0};
    doReset();
    setReq(9'h1FF);
    writeCfg(9'h000);
    foreach (seq[i]) txn(seq[i], "R5 all low round robin");
  endtask

  task automatic tFrameHeld();
    doReset();
    setReq(9'h1FF);
    chkGnt(0, "R6 before held frame");
    frameN = 1'b0;
    repeat (4) @(negedge clk);
    frameN = 1'b1;
    @(negedge clk);
    txn(1, "R6 held frame advances once");
    txn(0, "R6 after held frame");
    txn(2, "R6 after held frame");
  endtask

  task automatic tPreempt();
    doReset();
    setReq(9'h020);
    chkGnt(5, "R7 low requester alone");
    setReq(9'h021);
    chkGnt(0, "R7 higher request pre-empts");
    checks++;
    if (gntN[5] !== 1'b1 || $countones(~gntN) != 1) begin
      errors++;
      $display("FAIL R8: gntN=%h expected single grant on master 0", gntN);
    end
    setReq(9'h023);
    chkGnt(0, "R7 lower request ignored");
    setReq(9'h022);
    chkGnt(1, "R7 grant moves when top drops");
  endtask

  task automatic tDeferred();
    doReset();
    setReq(9'h005);
    writeCfg(9'h004);
    txn(0, "R10 write not yet applied");
    txn(2, "R10 new high member");
    txn(0, "R10 former high member served in low group");
  endtask

  task automatic tCredit();
    doReset();
    setReq(9'h008);
    txn(3, "R11 lone low requester");
    setReq(9'h1FF);
    txn(0, "R11 internal after low credit");
    txn(4, "R11 low pointer follows credited master");
  endtask

  initial begin
    tResetPark();
    tDefaultRot();
    tExample();
    tAllHigh();
    tAllLow();
    tFrameHeld();
    tPreempt();
    tDeferred();
    tCredit();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule